// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block is a register-mapped interrupt controller for a single processor. It takes a parameterised number of level-sensitive interrupt sources and groups them into banks of 32. Each bank has a mask register that software can load directly or change bit by bit through a write-one-to-enable alias and a write-one-to-disable alias. Each bank also has a read-only view of the sources that are both asserted and enabled.

When at least one enabled source is active and no vector is outstanding, the controller chooses the lowest-numbered candidate, latches that number and raises its processor interrupt line. The number stays frozen until software writes an acknowledge, and the line then stays low for a short gap before the next vector is taken. A configuration register holds an autoidle flag, which can be read back, and a soft-reset request. The request returns every register to its default and reports completion through a status flag after a fixed number of cycles.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After the reset input, every mask bit reads 1, every pending register reads 0, the vector register (0x040) reads 0, `irq_o` is low, the config register (0x010) reads 0 and status bit 0 (0x014) reads 1.
- R2: Bank n occupies 0x080+0x20·n. A write to its mask register (+0x04) replaces the mask. Each 1 bit written to the enable alias (+0x08) clears that mask bit, and each 1 bit written to the disable alias (+0x0C) sets it. Zero bits leave the mask unchanged, and both aliases read 0.
- R3: The pending register of bank n (+0x18) reads source AND NOT mask for the 32 sources of that bank. Bit i stands for source 32·n+i.
- R4: Source 0 is reserved and is never chosen. When no vector is latched, the lowest-numbered enabled active source from 1 upward is latched on the next clock edge. The vector register then shows it in bits [6:0], and `irq_o` is high exactly while that value is nonzero.
- R5: A latched vector does not change when sources or masks change, including when a lower-numbered source asserts.
- R6: A write to 0x048 with bit 0 set acknowledges the latched vector. On that edge the vector returns to 0, `irq_o` stays low for two cycles, and a new vector can be latched on the second edge after the acknowledge. A write with bit 0 clear has no effect.
- R7: Writing config bit 1 starts a soft reset. Status bit 0 reads 0 from the next edge and reads 1 again 4 edges after the request. Config bit 1 reads 1 while the reset runs, then self-clears. Masks, vector and autoidle return to their defaults, and config writes made during the reset are ignored.
- R8: Config bit 0 is the autoidle flag. It reads back the last value written and has no other effect.
- R9: The revision register (0x000) reads the `REV_CODE` parameter in bits [7:0], with the major number in [7:4] and the minor number in [3:0], and zero above.
- R10: `NUM_SRC` may be set to 96 or 128. Vector numbers up to NUM_SRC-1 are reported, and any address that is not a listed register, including bank addresses beyond the last bank, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with `NUM_SRC` = 128, so that a fourth bank exists. This makes vector 127 in bit 31 of the last bank reachable, as well as the first out-of-range bank address at 0x100. A behavioural model steps the masks, the vector latch, the acknowledge gap and the soft-reset countdown at each edge. The bench compares `irq_o` with this model on every cycle, and during a long randomised phase it also compares the vector register, acknowledging at random points.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
package ivc_pkg;
  localparam int MAX_SRC = 128;
  localparam int BANK_W  = 32;
  localparam int VEC_W   = 7;

  localparam logic [11:0] OFF_REV  = 12'h000;
  localparam logic [11:0] OFF_CFG  = 12'h010;
  localparam logic [11:0] OFF_STAT = 12'h014;
  localparam logic [11:0] OFF_VEC  = 12'h040;
  localparam logic [11:0] OFF_ACK  = 12'h048;
  // bank n lives at 0x080 + 0x20*n; upper address bits [11:5] select it
  localparam int BANK_TAG0 = 4;

  localparam logic [4:0] SUB_MASK = 5'h04;
  localparam logic [4:0] SUB_EN   = 5'h08;
  localparam logic [4:0] SUB_DIS  = 5'h0C;
  localparam logic [4:0] SUB_PEND = 5'h18;

  typedef enum logic [1:0] {MW_NONE, MW_LOAD, MW_ENABLE, MW_DISABLE} mask_op_e;

  typedef logic [MAX_SRC-1:0] wide_t;

  // lowest set bit at index 1 or above; 0 means none
  function automatic logic [VEC_W-1:0] lowest_from_one(input wide_t v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = MAX_SRC - 1; i >= 1; i--) begin
      if (v[i]) r = VEC_W'(i);
    end
    return r;
  endfunction

  // next mask value for a given write operation
  function automatic logic [BANK_W-1:0] mask_next(input mask_op_e op,
                                                  input logic [BANK_W-1:0] cur,
                                                  input logic [BANK_W-1:0] wd);
    logic [BANK_W-1:0] r;
    case (op)
      MW_LOAD:    r = wd;
      MW_ENABLE:  r = cur & ~wd;
      MW_DISABLE: r = cur | wd;
      default:    r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ivc_mask_bank.sv
`timescale 1ns/1ps
module ivc_mask_bank
  import ivc_pkg::*;
#(
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_en,
  input  logic [11:0]       addr,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] src,
  output logic [BANK_W-1:0] mask_q,
  output logic [BANK_W-1:0] pend
);
  localparam logic [6:0] TAG = 7'(BANK_TAG0 + BANK_ID);

  logic     hit;
  mask_op_e op;
  logic     en_wr;
  logic     dis_wr;

  assign hit = wr_en && (addr[11:5] == TAG);

  always_comb begin
    op = MW_NONE;
    if (hit) begin
      case (addr[4:0])
        SUB_MASK: op = MW_LOAD;
        SUB_EN:   op = MW_ENABLE;
        SUB_DIS:  op = MW_DISABLE;
        default:  op = MW_NONE;
      endcase
    end
  end

  assign en_wr  = (op == MW_ENABLE);
  assign dis_wr = (op == MW_DISABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '1;
    else if (soft_clr) mask_q <= '1;
    else               mask_q <= mask_next(op, mask_q, wdata);
  end

  assign pend = src & ~mask_q;

  AST_EN_ALIAS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !soft_clr) |=> ((mask_q & $past(wdata)) == '0)); // R2
  AST_DIS_ALIAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_wr && !soft_clr) |=> ((mask_q & $past(wdata)) == $past(wdata))); // R2
  AST_ALIAS_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_wr || dis_wr) && !soft_clr) |=>
      ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata)))); // R2
endmodule

// File: rtl/ivc_vec_latch.sv
`timescale 1ns/1ps
module ivc_vec_latch
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               ack_evt,
  input  logic [NUM_SRC-1:0] pend,
  output logic [VEC_W-1:0]   vec_q,
  output logic               latch_evt,
  output logic               irq_o
);
  wide_t            pend_wide;
  logic [VEC_W-1:0] cand;
  logic             busy;
  logic             take_ack;
  logic             cool_q;

  always_comb begin
    pend_wide = '0;
    pend_wide[NUM_SRC-1:0] = pend;
  end

  assign cand      = lowest_from_one(pend_wide);
  assign busy      = (vec_q != '0);
  assign take_ack  = ack_evt && busy;
  assign latch_evt = !busy && !cool_q && (cand != '0) && !soft_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      cool_q <= 1'b0;
    end else if (soft_clr) begin
      vec_q  <= '0;
      cool_q <= 1'b0;
    end else if (take_ack) begin
      vec_q  <= '0;
      cool_q <= 1'b1;
    end else begin
      cool_q <= 1'b0;
      if (latch_evt) vec_q <= cand;
    end
  end

  assign irq_o = busy;

  AST_VEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack_evt && !soft_clr) |=> $stable(vec_q)); // R5
  AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    take_ack |=> (!irq_o ##1 !irq_o)); // R6
  AST_VEC_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ((($past(pend_wide) >> vec_q) & wide_t'(1)) == wide_t'(1))); // R4
  AST_VEC_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (($past(pend_wide) & ((wide_t'(1) << vec_q) - wide_t'(1))
                       & ~wide_t'(1)) == '0)); // R4
endmodule

// File: rtl/ivc_sysctl.sv
`timescale 1ns/1ps
module ivc_sysctl #(
  parameter int SRST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_bits,
  output logic       aidle_q,
  output logic       busy_q,
  output logic       done_q,
  output logic       soft_clr
);
  localparam int CNT_W = $clog2(SRST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             req;

  assign req      = cfg_wr && cfg_bits[1] && !busy_q;
  assign soft_clr = req || busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aidle_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b1;
      cnt_q   <= '0;
    end else if (req) begin
      aidle_q <= 1'b0;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      cnt_q   <= CNT_W'(SRST_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (cfg_wr) begin
      aidle_q <= cfg_bits[0];
    end
  end

  AST_SRST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (!done_q && busy_q)); // R7
  AST_SRST_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q); // R7
  AST_SRST_AIDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !aidle_q); // R7
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int          NUM_SRC     = 96,
  parameter logic [7:0]  REV_CODE    = 8'h21,
  parameter int          SRST_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr_i,
  input  logic [11:0]        bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o
);
  localparam int NUM_BANKS = NUM_SRC / BANK_W;

  logic [BANK_W-1:0]  mask_all [NUM_BANKS];
  logic [NUM_SRC-1:0] pend_all;
  logic               soft_clr;
  logic               ack_evt;
  logic               cfg_wr;
  logic               latch_evt;
  logic               aidle_q;
  logic               srst_busy;
  logic               srst_done;
  logic [VEC_W-1:0]   vec_q;

  assign ack_evt = bus_wr_i && (bus_addr_i == OFF_ACK) && bus_wdata_i[0];
  assign cfg_wr  = bus_wr_i && (bus_addr_i == OFF_CFG);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ivc_mask_bank #(.BANK_ID(b)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .wr_en    (bus_wr_i),
      .addr     (bus_addr_i),
      .wdata    (bus_wdata_i),
      .src      (src_i[b*BANK_W +: BANK_W]),
      .mask_q   (mask_all[b]),
      .pend     (pend_all[b*BANK_W +: BANK_W])
    );
  end

  ivc_vec_latch #(.NUM_SRC(NUM_SRC)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .ack_evt   (ack_evt),
    .pend      (pend_all),
    .vec_q     (vec_q),
    .latch_evt (latch_evt),
    .irq_o     (irq_o)
  );

  ivc_sysctl #(.SRST_CYCLES(SRST_CYCLES)) u_sys (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_bits (bus_wdata_i[1:0]),
    .aidle_q  (aidle_q),
    .busy_q   (srst_busy),
    .done_q   (srst_done),
    .soft_clr (soft_clr)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFF_REV:  bus_rdata_o = {24'h0, REV_CODE};
      OFF_CFG:  bus_rdata_o = {30'h0, srst_busy, aidle_q};
      OFF_STAT: bus_rdata_o = {31'h0, srst_done};
      OFF_VEC:  bus_rdata_o = {{(32-VEC_W){1'b0}}, vec_q};
      default: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (bus_addr_i[11:5] == 7'(BANK_TAG0 + b)) begin
            if (bus_addr_i[4:0] == SUB_MASK) bus_rdata_o = mask_all[b];
            if (bus_addr_i[4:0] == SUB_PEND) bus_rdata_o = pend_all[b*BANK_W +: BANK_W];
          end
        end
      end
    endcase
  end

  AST_ACK_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt && irq_o && !soft_clr) |=> !irq_o); // R6
  AST_NO_LATCH_IN_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> !irq_o); // R7
  AST_LATCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |=> irq_o); // R4
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  localparam int NS = 128;
  localparam int NB = NS / 32;
  localparam logic [7:0] REV = 8'h21;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic         bus_wr = 1'b0;
  logic [11:0]  addr = 12'h040;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NUM_SRC(NS), .REV_CODE(REV), .SRST_CYCLES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(bus_wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_mask [NB];
  int  m_vec;
  bit  m_cool, m_busy, m_done, m_aidle;
  int  m_cnt;

  task automatic model_reset();
    for (int b = 0; b < NB; b++) m_mask[b] = 32'hFFFF_FFFF;
    m_vec = 0; m_cool = 0; m_busy = 0; m_done = 1; m_aidle = 0; m_cnt = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit req, clr;
      int cand;
      req = bus_wr && addr == 12'h010 && wdata[1] && !m_busy;
      clr = req || m_busy;
      cand = 0;
      for (int i = NS - 1; i >= 1; i--)
        if (src[i] && !m_mask[i / 32][i % 32]) cand = i;
      if (clr) begin
        for (int b = 0; b < NB; b++) m_mask[b] = 32'hFFFF_FFFF;
        m_vec = 0; m_cool = 0;
      end else begin
        if (bus_wr)
          for (int b = 0; b < NB; b++) begin
            if (addr == 12'h084 + 12'(32 * b)) m_mask[b] = wdata;
            if (addr == 12'h088 + 12'(32 * b)) m_mask[b] = m_mask[b] & ~wdata;
            if (addr == 12'h08C + 12'(32 * b)) m_mask[b] = m_mask[b] | wdata;
          end
        if (bus_wr && addr == 12'h048 && wdata[0] && m_vec != 0) begin
          m_vec = 0; m_cool = 1;
        end else if (m_cool) m_cool = 0;
        else if (m_vec == 0 && cand != 0) m_vec = cand;
      end
      if (req) begin
        m_busy = 1; m_done = 0; m_cnt = 3; m_aidle = 0;
      end else if (m_busy) begin
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
        else m_cnt--;
      end else if (bus_wr && addr == 12'h010) m_aidle = wdata[0];
    end
  end

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 12'h000) r = {24'h0, REV};
    else if (a == 12'h010) r = {30'h0, m_busy, m_aidle};
    else if (a == 12'h014) r = {31'h0, m_done};
    else if (a == 12'h040) r = 32'(m_vec);
    else
      for (int b = 0; b < NB; b++) begin
        if (a == 12'h084 + 12'(32 * b)) r = m_mask[b];
        if (a == 12'h098 + 12'(32 * b)) r = src[b*32 +: 32] & ~m_mask[b];
      end
    return r;
  endfunction

  // ---------------- checking helpers ----------------
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      n_chk++;
      if (irq !== (m_vec != 0)) begin
        n_err++;
        $display("FAIL R4 irq_o per cycle: actual=%b expected=%b", irq, (m_vec != 0));
      end
    end
  end

  task automatic check_now(input logic [11:0] a, input string tag);
    logic [31:0] exp;
    addr = a;
    #1;
    exp = model_read(a);
    n_chk++;
    if (rdata !== exp) begin
      n_err++;
      $display("FAIL %s read 0x%03h: actual=0x%08h expected=0x%08h", tag, a, rdata, exp);
    end
  endtask

  task automatic check_lit(input logic [11:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_err++;
      $display("FAIL %s read 0x%03h: actual=0x%08h expected=0x%08h", tag, a, rdata, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; addr = 12'h040; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  // ---------------- stimulus ----------------
  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state, R9 revision
    check_lit(12'h000, 32'h0000_0021, "R9");
    check_lit(12'h010, 32'h0, "R1");
    check_lit(12'h014, 32'h1, "R1");
    check_lit(12'h040, 32'h0, "R1");
    for (int b = 0; b < NB; b++) begin
      check_lit(12'h084 + 12'(32 * b), 32'hFFFF_FFFF, "R1");
      check_lit(12'h098 + 12'(32 * b), 32'h0, "R1");
    end

    // R3: active but masked sources stay invisible
    src[5] = 1; src[9] = 1; src[40] = 1;
    idle(2);
    check_lit(12'h098, 32'h0, "R3");
    check_lit(12'h040, 32'h0, "R4");

    // R2 enable alias, R3 pending, R4 lowest
    wr_reg(12'h088, (32'h1 << 9) | (32'h1 << 5));
    check_lit(12'h084, ~((32'h1 << 9) | (32'h1 << 5)), "R2");
    check_lit(12'h098, (32'h1 << 9) | (32'h1 << 5), "R3");
    idle(1);
    check_lit(12'h040, 32'd5, "R4");
    check_now(12'h0B8, "R3");

    // R5: lower source asserts and is enabled, vector stays
    src[3] = 1;
    wr_reg(12'h088, 32'h8);
    idle(2);
    check_lit(12'h040, 32'd5, "R5");

    // R6: ack with bit 0 clear is ignored
    wr_reg(12'h048, 32'h2);
    check_lit(12'h040, 32'd5, "R6");
    // R6: real ack, two-cycle gap then lowest (3)
    wr_reg(12'h048, 32'h1);
    check_lit(12'h040, 32'd0, "R6");
    idle(1);
    check_lit(12'h040, 32'd0, "R6");
    idle(1);
    check_lit(12'h040, 32'd3, "R6");

    // R2 disable alias with zero bits elsewhere
    wr_reg(12'h08C, 32'h8);
    check_lit(12'h084, ~((32'h1 << 9) | (32'h1 << 5)) , "R2");
    wr_reg(12'h048, 32'h1);
    idle(2);
    check_lit(12'h040, 32'd5, "R2");

    // R4 source 0 reserved
    src = '0;
    src[0] = 1;
    wr_reg(12'h048, 32'h1);
    wr_reg(12'h088, 32'h1);
    idle(3);
    check_lit(12'h098, 32'h1 | 32'h0, "R4");
    check_lit(12'h040, 32'd0, "R4");

    // R10 top vector in last bank
    src[127] = 1;
    wr_reg(12'h0E8, 32'h8000_0000);
    idle(2);
    check_lit(12'h040, 32'd127, "R10");
    check_lit(12'h0F8, 32'h8000_0000, "R10");
    check_lit(12'h100, 32'h0, "R10");
    check_lit(12'h118, 32'h0, "R10");
    check_lit(12'h088, 32'h0, "R2");

    // R2 direct mask load
    wr_reg(12'h0A4, 32'h1234_5678);
    check_lit(12'h0A4, 32'h1234_5678, "R2");

    // R8 autoidle
    wr_reg(12'h010, 32'h1);
    check_lit(12'h010, 32'h1, "R8");
    wr_reg(12'h010, 32'h0);
    check_lit(12'h010, 32'h0, "R8");
    wr_reg(12'h010, 32'h1);

    // R7 soft reset timeline: request edge then 4 edges
    wr_reg(12'h010, 32'h2);
    check_lit(12'h014, 32'h0, "R7");
    check_lit(12'h010, 32'h2, "R7");
    check_lit(12'h040, 32'h0, "R7");
    wr_reg(12'h010, 32'h1);
    check_lit(12'h014, 32'h0, "R7");
    idle(1);
    check_lit(12'h014, 32'h0, "R7");
    idle(1);
    check_lit(12'h014, 32'h1, "R7");
    check_lit(12'h010, 32'h0, "R7");
    check_lit(12'h0A4, 32'hFFFF_FFFF, "R7");
    check_lit(12'h0E4, 32'hFFFF_FFFF, "R7");

    // randomised phase against the model (R4 R5 R6)
    for (int b = 0; b < NB; b++) wr_reg(12'h088 + 12'(32 * b), 32'hFFFF_FFFF);
    wr_reg(12'h08C, 32'h0000_00F0);
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      bus_wr = 1'b0; wdata = '0;
      if (c % 9 == 0)
        src = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
               $urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      check_now(12'h040, "R5");
      if (irq && ($urandom % 3 == 0)) begin
        bus_wr = 1'b1; addr = 12'h048; wdata = 32'h1;
      end
    end
    @(negedge clk);
    bus_wr = 1'b0; addr = 12'h040;
    check_now(12'h098, "R3");
    check_now(12'h0D8, "R3");
    idle(2);
    finish_up();
  end
endmodule